// File: doc/BRIEF.md
# Read-Port Width Adapter with Piece Ordering

This block sits on the read side of a 36-bit queue and hands its words to a consumer whose bus is 36, 18 or 9 bits wide. It takes one full word from the queue, holds it, and sends it out as one, two or four pieces. A configuration bit picks the order of the pieces: most significant piece first, or least significant piece first. Both sides use a valid/ready handshake. A new word is taken from the queue only when the last piece of the held word leaves, and it can be taken in that same cycle.

The width and order are read from configuration pins while the main reset is low, and they do not change after that. A separate clear input empties the holding stage and restarts the piece sequence. The stored configuration is not affected by the clear. The write side, the queue storage and its flags belong to other blocks.

Top module: `rdWidthAdapter`

## Requirements
- R1: While `rstN` is low and on the first cycle after it rises, `outValid` is 0 and `inReady` is 1.
- R2: Width code 2'b00 selects 36-bit mode. Each accepted input word appears once on `outData` as a single transfer. With `outReady` held at 1, a new word is accepted in the same cycle that the previous one is delivered.
- R3: Width code 2'b01 selects 18-bit mode. Each word goes out as two pieces on `outData[17:0]`. With `cfgBigEnd`=1, bits 35:18 go first. With `cfgBigEnd`=0, bits 17:0 go first. `outData[35:18]` is 0 in this mode.
- R4: Width code 2'b10 selects 9-bit mode. Each word goes out as four pieces on `outData[8:0]`. With `cfgBigEnd`=1, the order is bits 35:27, 26:18, 17:9, 8:0. With `cfgBigEnd`=0, the order is the reverse. `outData[35:9]` is 0 in this mode.
- R5: While a held word still has pieces left to send after the current one, `inReady` is 0. `inReady` goes to 1 in the cycle the last piece is accepted.
- R6: While `outValid` is 1 and `outReady` is 0, `outValid` and `outData` hold their values on the next cycle.
- R7: `cfgWidth` and `cfgBigEnd` are sampled only while `rstN` is low. Changing them after reset has no effect on the piece count or the piece order.
- R8: A cycle with `softClr`=1 discards the held word and any pieces left from it, and `inReady` is 0 in that cycle. The width and order set at reset are kept for the words that follow.
- R9: Width code 2'b11 behaves the same as 36-bit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low. Configuration is loaded while it is low. |
| softClr | input | 1 | Clears the held word and the piece position. Configuration is kept. |
| cfgWidth | input | 2 | Output width code: 00 = 36, 01 = 18, 10 = 9, 11 = 36 |
| cfgBigEnd | input | 1 | 1 = most significant piece first |
| inData | input | 36 | Word from the queue |
| inValid | input | 1 | Queue has a word |
| inReady | output | 1 | Adapter takes the word this cycle |
| outData | output | 36 | Current piece, placed in the low bits |
| outValid | output | 1 | A piece is on offer |
| outReady | input | 1 | Consumer takes the piece |

## Verification
The assertions check on every cycle that no word is popped while pieces remain, that the piece index stays inside the current mode's range, that a stalled piece holds steady, that unused upper bits are zero, and that the stored configuration never moves after reset. Only the bench scenarios can show the actual piece values and their order against a known word. The same holds for whether the last-piece pop and the next word line up cycle for cycle, for ignoring configuration changes after reset, and for dropping a half-sent word on a clear.

// File: rtl/rdwa_pkg.sv
package rdwa_pkg;

  typedef enum logic [1:0] {
    MODE_LONG = 2'b00,
    MODE_WORD = 2'b01,
    MODE_BYTE = 2'b10,
    MODE_RSVD = 2'b11
  } widthMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a new word from the queue
    logic step;   // advance to next piece
    logic clear;  // drop the held word
  } ctlStrobe_t;

  localparam int IDX_W = 2;

  function automatic logic [IDX_W-1:0] lastIndex(widthMode_e m);
    case (m)
      MODE_WORD: lastIndex = IDX_W'(1);
      MODE_BYTE: lastIndex = IDX_W'(3);
      default:   lastIndex = '0;
    endcase
  endfunction

endpackage

// File: rtl/rdwa_ctrl.sv
module rdwa_ctrl
  import rdwa_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             softClr,
  input  logic [1:0]       cfgWidth,
  input  logic             cfgBigEnd,
  input  logic             inValid,
  input  logic             outReady,
  output logic             inReady,
  output logic             outValid,
  output ctlStrobe_t       strobe,
  output widthMode_e       modeQ,
  output logic             bigEndQ,
  output logic [IDX_W-1:0] idxQ
);

  logic             fullQ;
  logic [IDX_W-1:0] lastIdx;
  logic             isLast;
  logic             finish;

  assign lastIdx  = lastIndex(modeQ);
  assign isLast   = (idxQ == lastIdx);
  assign finish   = fullQ && outReady && isLast;
  assign outValid = fullQ;
  assign inReady  = !softClr && (!fullQ || finish);

  always_comb begin
    strobe       = '0;
    strobe.load  = inValid && inReady;
    strobe.step  = fullQ && outReady && !isLast && !softClr;
    strobe.clear = softClr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ   <= widthMode_e'(cfgWidth);
      bigEndQ <= cfgBigEnd;
      fullQ   <= 1'b0;
      idxQ    <= '0;
    end else if (strobe.clear) begin
      fullQ <= 1'b0;
      idxQ  <= '0;
    end else if (strobe.load) begin
      fullQ <= 1'b1;
      idxQ  <= '0;
    end else if (finish) begin
      fullQ <= 1'b0;
      idxQ  <= '0;
    end else if (strobe.step) begin
      idxQ <= idxQ + 1'b1;
    end
  end

  // R5: no pop while pieces remain
  a_r5_no_pop_midword: assert property (@(posedge clk) disable iff (!rstN)
    (fullQ && !isLast) |-> !inReady);

  // R3/R4: index never exceeds the mode's last piece
  a_r4_idx_in_range: assert property (@(posedge clk) disable iff (!rstN)
    idxQ <= lastIdx);

  // R7: configuration frozen after reset
  a_r7_cfg_frozen: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ($stable(modeQ) && $stable(bigEndQ)));

  // R2: single-piece modes never move the index
  a_r2_long_single: assert property (@(posedge clk) disable iff (!rstN)
    ((modeQ == MODE_LONG) || (modeQ == MODE_RSVD)) |-> (idxQ == '0));

  // R8: clear empties the stage
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    softClr |=> !fullQ);

endmodule

// File: rtl/rdwa_dpath.sv
module rdwa_dpath
  import rdwa_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  widthMode_e        modeQ,
  input  logic              bigEndQ,
  input  logic [IDX_W-1:0]  idxQ,
  input  logic [DATA_W-1:0] inData,
  input  logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData
);

  localparam int HALF_W  = DATA_W / 2;
  localparam int QUART_W = DATA_W / 4;
  localparam int NBYTE   = 4;

  logic [DATA_W-1:0]  holdQ;
  logic [HALF_W-1:0]  halfPart [2];
  logic [QUART_W-1:0] quartPart [NBYTE];
  logic               halfSlot;
  logic [IDX_W-1:0]   quartSlot;

  always_ff @(posedge clk) begin
    if (!rstN) holdQ <= '0;
    else if (strobe.load) holdQ <= inData;
  end

  // slot 0 is least significant
  for (genvar h = 0; h < 2; h++) begin : g_half
    assign halfPart[h] = holdQ[h*HALF_W +: HALF_W];
  end
  for (genvar q = 0; q < NBYTE; q++) begin : g_quart
    assign quartPart[q] = holdQ[q*QUART_W +: QUART_W];
  end

  assign halfSlot  = bigEndQ ? ~idxQ[0] : idxQ[0];
  assign quartSlot = bigEndQ ? (IDX_W'(NBYTE-1) - idxQ) : idxQ;

  always_comb begin
    case (modeQ)
      MODE_WORD: outData = {{(DATA_W-HALF_W){1'b0}}, halfPart[halfSlot]};
      MODE_BYTE: outData = {{(DATA_W-QUART_W){1'b0}}, quartPart[quartSlot]};
      default:   outData = holdQ;
    endcase
  end

  // R6: stalled piece holds
  a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rstN || strobe.clear)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R3: upper half zero in 18-bit mode
  a_r3_word_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_WORD) |-> (outData[DATA_W-1:HALF_W] == '0));

  // R4: upper bits zero in 9-bit mode
  a_r4_byte_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_BYTE) |-> (outData[DATA_W-1:QUART_W] == '0));

endmodule

// File: rtl/rdWidthAdapter.sv
module rdWidthAdapter
  import rdwa_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softClr,
  input  logic [1:0]        cfgWidth,
  input  logic              cfgBigEnd,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  input  logic              outReady
);

  ctlStrobe_t       strobe;
  widthMode_e       modeQ;
  logic             bigEndQ;
  logic [IDX_W-1:0] idxQ;

  rdwa_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .softClr  (softClr),
    .cfgWidth (cfgWidth),
    .cfgBigEnd(cfgBigEnd),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe),
    .modeQ    (modeQ),
    .bigEndQ  (bigEndQ),
    .idxQ     (idxQ)
  );

  rdwa_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .modeQ    (modeQ),
    .bigEndQ  (bigEndQ),
    .idxQ     (idxQ),
    .inData   (inData),
    .outValid (outValid),
    .outReady (outReady),
    .outData  (outData)
  );

endmodule

// File: tb/rdWidthAdapter_bench.sv
module rdWidthAdapter_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        softClr;
  logic [1:0]  cfgWidth;
  logic        cfgBigEnd;
  logic [35:0] inData;
  logic        inValid;
  logic        inReady;
  logic [35:0] outData;
  logic        outValid;
  logic        outReady;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  rdWidthAdapter u_rdWidthAdapter (
    .clk(clk), .rstN(rstN), .softClr(softClr), .cfgWidth(cfgWidth),
    .cfgBigEnd(cfgBigEnd), .inData(inData), .inValid(inValid),
    .inReady(inReady), .outData(outData), .outValid(outValid),
    .outReady(outReady)
  );

  // {mode[1:0], bigEnd, word[35:0]}
  localparam logic [38:0] VEC [8] = '{
    {2'b00, 1'b0, 36'h1_2345_6789},
    {2'b01, 1'b1, 36'h9_ABCD_1234},
    {2'b01, 1'b0, 36'h8_1357_2468},
    {2'b10, 1'b1, 36'hF_0F1E_2D3C},
    {2'b10, 1'b0, 36'h1_2345_6789},
    {2'b11, 1'b1, 36'h7_7777_0001},
    {2'b00, 1'b1, 36'hF_FFFF_FFFF},
    {2'b10, 1'b1, 36'h0_8040_2010}
  };

  function automatic int nPieces(logic [1:0] m);
    return (m == 2'b01) ? 2 : (m == 2'b10) ? 4 : 1;
  endfunction

  function automatic logic [35:0] expPiece(logic [1:0] m, logic be, logic [35:0] w, int k);
    int n = nPieces(m);
    int pw = 36 / n;
    int slot = be ? (n - 1 - k) : k;
    logic [35:0] mask = (n == 1) ? 36'hF_FFFF_FFFF : ((36'd1 << pw) - 36'd1);
    return (w >> (slot * pw)) & mask;
  endfunction

  task automatic check(bit ok, string req, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset(logic [1:0] m, logic be);
    @(negedge clk);
    rstN = 1'b0; cfgWidth = m; cfgBigEnd = be;
    inValid = 1'b0; outReady = 1'b0; softClr = 1'b0; inData = '0;
    #1;
    check(!outValid && inReady, "R1 during reset", {34'd0, outValid, inReady}, 36'd1);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(!outValid && inReady, "R1 after reset", {34'd0, outValid, inReady}, 36'd1);
  endtask

  task automatic runWord(logic [1:0] m, logic be, logic [35:0] w, bit stall, string req);
    int n = nPieces(m);
    int k = 0;
    int cyc = 0;
    bit popped = 0;
    while (k < n && cyc < 40) begin
      @(negedge clk);
      inValid = !popped; inData = w;
      outReady = stall ? cyc[0] : 1'b1;
      #1;
      if (inValid && inReady) popped = 1;
      if (outValid && outReady) begin
        check(outData == expPiece(m, be, w, k), req, outData, expPiece(m, be, w, k));
        k++;
      end
      cyc++;
    end
    check(k == n, {req, " piece count"}, 36'(k), 36'(n));
    @(negedge clk);
    inValid = 1'b0; outReady = 1'b1;
    #1;
    check(!outValid, {req, " drained"}, {35'd0, outValid}, 36'd0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 36'd0, 36'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [35:0] w1, w2;
    rstN = 1'b0; softClr = 1'b0; cfgWidth = 2'b00; cfgBigEnd = 1'b0;
    inValid = 1'b0; outReady = 1'b0; inData = '0;

    // Vector table: R2 long, R3 word, R4 byte, R9 reserved code
    for (int i = 0; i < 8; i++) begin
      doReset(VEC[i][38:37], VEC[i][36]);
      runWord(VEC[i][38:37], VEC[i][36], VEC[i][35:0], i[0],
              (VEC[i][38:37] == 2'b01) ? "R3" : (VEC[i][38:37] == 2'b10) ? "R4" :
              (VEC[i][38:37] == 2'b11) ? "R9" : "R2");
    end

    // R5 / R6: byte mode little-first, second word waits for last piece
    w1 = 36'h1_2345_6789; w2 = 36'hA_BCDE_F012;
    doReset(2'b10, 1'b0);
    @(negedge clk); inValid = 1'b1; inData = w1; outReady = 1'b0; #1;
    check(inReady, "R5 idle accepts", {35'd0, inReady}, 36'd1);
    @(negedge clk); inData = w2; #1;
    check(!inReady, "R5 mid-word blocked", {35'd0, inReady}, 36'd0);
    check(outValid && outData == expPiece(2'b10, 1'b0, w1, 0), "R6 first piece", outData, expPiece(2'b10, 1'b0, w1, 0));
    @(negedge clk); #1;
    check(outValid && outData == expPiece(2'b10, 1'b0, w1, 0), "R6 stalled hold", outData, expPiece(2'b10, 1'b0, w1, 0));
    @(negedge clk); outReady = 1'b1;
    for (int k = 0; k < 4; k++) begin
      if (k > 0) @(negedge clk);
      #1;
      check(outData == expPiece(2'b10, 1'b0, w1, k), "R5 piece order", outData, expPiece(2'b10, 1'b0, w1, k));
      check(inReady == (k == 3), "R5 ready only at last", {35'd0, inReady}, {35'd0, (k == 3)});
    end
    @(negedge clk); inValid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (k > 0) @(negedge clk);
      #1;
      check(outValid && outData == expPiece(2'b10, 1'b0, w2, k), "R5 next word", outData, expPiece(2'b10, 1'b0, w2, k));
    end
    @(negedge clk); #1;
    check(!outValid, "R5 drained", {35'd0, outValid}, 36'd0);

    // R2: back-to-back full rate in 36-bit mode
    w1 = 36'h3_1415_9265; w2 = 36'h2_7182_8182;
    doReset(2'b00, 1'b0);
    @(negedge clk); inValid = 1'b1; inData = w1; outReady = 1'b1; #1;
    @(negedge clk); inData = w2; #1;
    check(outValid && outData == w1 && inReady, "R2 first word with ready", outData, w1);
    @(negedge clk); inValid = 1'b0; #1;
    check(outValid && outData == w2, "R2 second word next cycle", outData, w2);
    @(negedge clk); #1;
    check(!outValid, "R2 single transfer each", {35'd0, outValid}, 36'd0);

    // R7: config pins changed after reset are ignored
    doReset(2'b01, 1'b1);
    @(negedge clk); cfgWidth = 2'b10; cfgBigEnd = 1'b0;
    runWord(2'b01, 1'b1, 36'hC_AFE0_BEEF, 1'b0, "R7");

    // R8: clear mid-word, config kept
    w1 = 36'h5_5AA5_0FF0; w2 = 36'h6_0102_0304;
    doReset(2'b10, 1'b1);
    @(negedge clk); inValid = 1'b1; inData = w1; outReady = 1'b0; #1;
    @(negedge clk); inValid = 1'b0; outReady = 1'b1; #1;
    check(outData == expPiece(2'b10, 1'b1, w1, 0), "R8 before clear", outData, expPiece(2'b10, 1'b1, w1, 0));
    @(negedge clk); softClr = 1'b1; inValid = 1'b1; inData = w2; #1;
    check(!inReady, "R8 no pop during clear", {35'd0, inReady}, 36'd0);
    @(negedge clk); softClr = 1'b0; inValid = 1'b0; #1;
    check(!outValid, "R8 stage empty", {35'd0, outValid}, 36'd0);
    runWord(2'b10, 1'b1, w2, 1'b0, "R8");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule